// File: doc/BRIEF.md
# Synchronous SRAM with Dual-Cycle Deselect Output

This block is a behavioural model of a synchronous static RAM for use inside a larger chip model. It has a small word array, captures address, data and control on the rising clock edge, writes whole words or single byte lanes, and returns read data either straight from the array (flow-through) or through one more output register (pipelined). The `pipe_mode` input picks the read path. It is meant to be set while the device is idle.

Deselects travel down the same pipe as reads. After a read, a deselect keeps the bus driven with the last read word for one extra full cycle, and only then releases it. Output enable and sleep act on the bus at once, without waiting for a clock. While sleep is high, every new command is dropped and the stored words are kept. The bus is given as a data vector `dq_out` plus a drive flag `dq_oe`. The pad ring turns `dq_oe` low into high impedance. Addresses come from an external burst sequencer.

Top module: `sync_sram_dcd`

## Requirements
- R1: After reset, `dq_oe` is low and stays low until a read reaches the output stage.
- R2: With `pipe_mode` low, a read sampled at clock edge k drives `dq_oe` high with the addressed word right after edge k.
- R3: With `pipe_mode` high, a read sampled at edge k drives the bus only after edge k+1. Right after edge k the bus still shows the previous stage, so a read that follows a deselect sees `dq_oe` low.
- R4: A write with `byte_wr_en` high, `glob_wr` low and some `byte_sel` bits set writes only the selected lanes. Lane i is `wdata[9*i+8:9*i]`, and the other lanes keep their old contents.
- R5: A write with `glob_wr` high stores all lanes, whatever `byte_wr_en` and `byte_sel` are.
- R6: With `byte_wr_en` high, `byte_sel` all zero and `glob_wr` low, the command is a read and the array is left unchanged.
- R7: `chip_en` low is a deselect. After a read, a deselect keeps the bus driven with the same word for one full extra cycle, and then releases it. In flow-through mode the bus is released after edge d+1, and in pipelined mode after edge d+2, where d is the edge that sampled the deselect.
- R8: The bus is not driven in the output cycle that belongs to a write.
- R9: A read sampled on the edge right after a write to the same address returns the newly written word.
- R10: `oe` low forces `dq_oe` low at once, without a clock edge. Raising `oe` again shows the word in flight, and the pipeline state is unchanged.
- R11: `sleep` high forces `dq_oe` low at once. Commands sampled while it is high have no effect, and the words written before sleep read back unchanged afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of the control pipeline |
| pipe_mode | input | 1 | 0 selects flow-through reads, 1 selects pipelined reads |
| chip_en | input | 1 | Selects the device. Low means deselect |
| glob_wr | input | 1 | Write all lanes |
| byte_wr_en | input | 1 | Enables per-lane writes chosen by byte_sel |
| byte_sel | input | 2 | One select bit per 9-bit lane |
| addr | input | 5 | Word address from the burst sequencer |
| wdata | input | 18 | Write data |
| oe | input | 1 | Asynchronous output enable, active high |
| sleep | input | 1 | Asynchronous sleep request, active high |
| dq_out | output | 18 | Read data. Valid while dq_oe is high |
| dq_oe | output | 1 | Bus drive flag. Low means high impedance |

## Verification
The bench targets the cycle in which the bus is released after a deselect in both modes. A single-cycle-deselect design would release it one cycle early, and a design that forgets the held word would change `dq_out` while still driving. It checks the first-access latency on both sides of the mode switch, because an extra or missing register would shift every read by a cycle. It checks byte-lane writes, the global-write override and the byte enable with no lanes selected, where a wrong decode would corrupt lanes or store a word that should have been a read. It also checks a read right after a write, which catches a stale array read, and the asynchronous oe and sleep paths, including a write attempted during sleep that must not be stored.

// File: rtl/sram_dcd_pkg.sv
package sram_dcd_pkg;

  typedef enum logic [1:0] {
    CMD_DESEL = 2'd0,
    CMD_READ  = 2'd1,
    CMD_WRITE = 2'd2
  } cmd_e;

  // Command decode: sleep or no select gives a deselect. A global write, or a
  // byte write with at least one lane, gives a write. Anything else is a read.
  function automatic cmd_e decode_cmd(input logic chip_en, input logic sleep,
                                      input logic glob_wr, input logic byte_wr_en,
                                      input logic any_lane);
    if (!chip_en || sleep) return CMD_DESEL;
    if (glob_wr || (byte_wr_en && any_lane)) return CMD_WRITE;
    return CMD_READ;
  endfunction

endpackage

// File: rtl/sram_dcd_in_stage.sv
module sram_dcd_in_stage
  import sram_dcd_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sleep,
  input  logic                     chip_en,
  input  logic                     glob_wr,
  input  logic                     byte_wr_en,
  input  logic [LANES-1:0]         byte_sel,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [LANES*LANE_W-1:0]  wdata,
  output cmd_e                     cmd_q,
  output logic [ADDR_W-1:0]        addr_q,
  output logic [LANES*LANE_W-1:0]  wdata_q,
  output logic [LANES-1:0]         lane_q
);

  localparam int DATA_W = LANES * LANE_W;

  function automatic logic [LANES-1:0] pick_lanes(input logic gw,
                                                  input logic [LANES-1:0] sel);
    return gw ? {LANES{1'b1}} : sel;
  endfunction

  cmd_e cmd_d;
  assign cmd_d = decode_cmd(chip_en, sleep, glob_wr, byte_wr_en, |byte_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= CMD_DESEL;
      addr_q  <= '0;
      wdata_q <= {DATA_W{1'b0}};
      lane_q  <= '0;
    end else begin
      cmd_q   <= cmd_d;
      addr_q  <= addr;
      wdata_q <= wdata;
      lane_q  <= pick_lanes(glob_wr, byte_sel);
    end
  end

  AST_GW_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_en && glob_wr && !sleep) |=> (cmd_q == CMD_WRITE && (&lane_q))); // R5

  AST_EMPTY_BYTE_WRITE_READS: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_en && !glob_wr && byte_wr_en && byte_sel == '0 && !sleep) |=> (cmd_q == CMD_READ)); // R6

  AST_SLEEP_DROPS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (cmd_q == CMD_DESEL)); // R11

endmodule

// File: rtl/sram_dcd_array.sv
module sram_dcd_array #(
  parameter int ADDR_W = 5,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_fire,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [LANES*LANE_W-1:0]  wr_data,
  input  logic [LANES-1:0]         wr_lanes,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [LANES*LANE_W-1:0]  rd_data
);

  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  function automatic logic [DATA_W-1:0] lane_bits(input logic [LANES-1:0] l);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < LANES; i++) r[i*LANE_W +: LANE_W] = {LANE_W{l[i]}};
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] merge_lanes(input logic [DATA_W-1:0] old_w,
                                                    input logic [DATA_W-1:0] new_w,
                                                    input logic [LANES-1:0] l);
    logic [DATA_W-1:0] m;
    m = lane_bits(l);
    return (old_w & ~m) | (new_w & m);
  endfunction

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] old_word;
  logic [DATA_W-1:0] merged_word;
  logic [DATA_W-1:0] keep_mask;

  assign old_word    = mem[wr_addr];
  assign merged_word = merge_lanes(old_word, wr_data, wr_lanes);
  assign keep_mask   = ~lane_bits(wr_lanes);

  // Self-timed write: the word is stored on the edge after capture.
  always_ff @(posedge clk) begin
    if (wr_fire) mem[wr_addr] <= merged_word;
  end

  assign rd_data = mem[rd_addr];

  AST_UNSELECTED_LANES_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> (((mem[$past(wr_addr)] ^ $past(old_word)) & $past(keep_mask)) == '0)); // R4

endmodule

// File: rtl/sram_dcd_out_path.sv
module sram_dcd_out_path
  import sram_dcd_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pipe_mode,
  input  logic                     oe,
  input  logic                     sleep,
  input  cmd_e                     cmd1,
  input  logic [LANES*LANE_W-1:0]  rd1,
  output logic [LANES*LANE_W-1:0]  dq_out,
  output logic                     dq_oe
);

  localparam int DATA_W = LANES * LANE_W;

  cmd_e              cmd2;
  logic [DATA_W-1:0] data2;
  cmd_e              prev_cmd;
  logic [DATA_W-1:0] hold_data;

  cmd_e              shown_cmd;
  logic [DATA_W-1:0] shown_data;
  logic [DATA_W-1:0] drv_data;
  logic              bus_on;

  // Flow-through shows stage 1, pipelined shows the output register.
  assign shown_cmd  = pipe_mode ? cmd2  : cmd1;
  assign shown_data = pipe_mode ? data2 : rd1;

  // A deselect right after a read keeps the last word on the bus one cycle.
  assign drv_data = (shown_cmd == CMD_READ) ? shown_data : hold_data;
  assign bus_on   = (shown_cmd == CMD_READ) ||
                    (shown_cmd == CMD_DESEL && prev_cmd == CMD_READ);

  assign dq_out = drv_data;
  assign dq_oe  = bus_on && oe && !sleep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd2      <= CMD_DESEL;
      data2     <= {DATA_W{1'b0}};
      prev_cmd  <= CMD_DESEL;
      hold_data <= {DATA_W{1'b0}};
    end else begin
      cmd2      <= cmd1;
      data2     <= rd1;
      prev_cmd  <= shown_cmd;
      hold_data <= drv_data;
    end
  end

  AST_SECOND_DESEL_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (shown_cmd == CMD_DESEL && $past(shown_cmd) == CMD_DESEL) |-> !dq_oe); // R7

  AST_HELD_WORD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (shown_cmd == CMD_DESEL && dq_oe) |-> $stable(dq_out)); // R7

  AST_PIPE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && $past(pipe_mode) && $past(cmd1) == CMD_READ && oe && !sleep)
      |-> (dq_oe && dq_out == $past(rd1))); // R3

endmodule

// File: rtl/sync_sram_dcd.sv
module sync_sram_dcd
  import sram_dcd_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pipe_mode,
  input  logic                     chip_en,
  input  logic                     glob_wr,
  input  logic                     byte_wr_en,
  input  logic [LANES-1:0]         byte_sel,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [LANES*LANE_W-1:0]  wdata,
  input  logic                     oe,
  input  logic                     sleep,
  output logic [LANES*LANE_W-1:0]  dq_out,
  output logic                     dq_oe
);

  localparam int DATA_W = LANES * LANE_W;

  cmd_e              cmd1;
  logic [ADDR_W-1:0] addr1;
  logic [DATA_W-1:0] wdata1;
  logic [LANES-1:0]  lanes1;
  logic [DATA_W-1:0] rd1;
  logic              wr_fire;

  sram_dcd_in_stage #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_in (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep      (sleep),
    .chip_en    (chip_en),
    .glob_wr    (glob_wr),
    .byte_wr_en (byte_wr_en),
    .byte_sel   (byte_sel),
    .addr       (addr),
    .wdata      (wdata),
    .cmd_q      (cmd1),
    .addr_q     (addr1),
    .wdata_q    (wdata1),
    .lane_q     (lanes1)
  );

  // A write already captured is dropped if sleep arrives before it lands.
  assign wr_fire = (cmd1 == CMD_WRITE) && !sleep;

  sram_dcd_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_fire  (wr_fire),
    .wr_addr  (addr1),
    .wr_data  (wdata1),
    .wr_lanes (lanes1),
    .rd_addr  (addr1),
    .rd_data  (rd1)
  );

  sram_dcd_out_path #(.LANES(LANES), .LANE_W(LANE_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .pipe_mode (pipe_mode),
    .oe        (oe),
    .sleep     (sleep),
    .cmd1      (cmd1),
    .rd1       (rd1),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe)
  );

  AST_WRITE_STAGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && cmd1 == CMD_WRITE) |-> !dq_oe); // R8

endmodule

// File: tb/sync_sram_dcd_bench.sv
module sync_sram_dcd_bench;
  localparam int ADDR_W = 5;
  localparam int LANES  = 2;
  localparam int LANE_W = 9;
  localparam int DW     = LANES * LANE_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pipe_mode = 1'b0;
  logic chip_en = 1'b0;
  logic glob_wr = 1'b0;
  logic byte_wr_en = 1'b0;
  logic [LANES-1:0] byte_sel = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic oe = 1'b1;
  logic sleep = 1'b0;
  logic [DW-1:0] dq_out;
  logic dq_oe;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sync_sram_dcd #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_sync_sram_dcd (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .chip_en(chip_en),
    .glob_wr(glob_wr), .byte_wr_en(byte_wr_en), .byte_sel(byte_sel),
    .addr(addr), .wdata(wdata), .oe(oe), .sleep(sleep),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic chk_on(input string req, input logic exp);
    checks++;
    if (dq_oe !== exp) begin
      errors++;
      $display("FAIL %s: dq_oe actual %b expected %b", req, dq_oe, exp);
    end
  endtask

  task automatic chk_word(input string req, input logic [DW-1:0] exp);
    checks++;
    if (dq_oe !== 1'b1 || dq_out !== exp) begin
      errors++;
      $display("FAIL %s: dq_oe/dq_out actual %b/%h expected 1/%h", req, dq_oe, dq_out, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic cmd_idle();
    chip_en = 1'b0; glob_wr = 1'b0; byte_wr_en = 1'b0; byte_sel = '0;
  endtask

  task automatic cmd_read(input logic [ADDR_W-1:0] a);
    chip_en = 1'b1; glob_wr = 1'b0; byte_wr_en = 1'b0; byte_sel = '0; addr = a;
  endtask

  task automatic cmd_write(input logic [ADDR_W-1:0] a, input logic [DW-1:0] d,
                           input logic gw, input logic bwe, input logic [LANES-1:0] sel);
    chip_en = 1'b1; glob_wr = gw; byte_wr_en = bwe; byte_sel = sel; addr = a; wdata = d;
  endtask

  task automatic t_reset();
    #2;
    chk_on("R1 during reset", 1'b0);
    tick(); tick();
    rst_n = 1'b1;
    tick();
    chk_on("R1 after reset", 1'b0);
    tick();
    chk_on("R1 idle", 1'b0);
  endtask

  task automatic t_flow_read();
    cmd_write(5'd3, 18'h21A5C, 1'b1, 1'b0, 2'b00); tick();
    chk_on("R8 write stage off", 1'b0);
    cmd_write(5'd4, 18'h0F0F0, 1'b1, 1'b0, 2'b00); tick();
    cmd_read(5'd4); tick();
    chk_word("R9 read after write", 18'h0F0F0);
    cmd_read(5'd3); tick();
    chk_word("R2 flow-through read", 18'h21A5C);
    cmd_read(5'd4); tick();
    chk_word("R2 back-to-back read", 18'h0F0F0);
    cmd_idle(); tick();
  endtask

  task automatic t_flow_dcd();
    cmd_idle(); tick();
    cmd_read(5'd3); tick();
    chk_word("R2 read before deselect", 18'h21A5C);
    cmd_idle(); tick();
    chk_word("R7 flow-through hold cycle", 18'h21A5C);
    tick();
    chk_on("R7 flow-through release", 1'b0);
  endtask

  task automatic t_bytes();
    cmd_write(5'd8, 18'h3FFFF, 1'b1, 1'b0, 2'b00); tick();
    cmd_write(5'd8, 18'h00000, 1'b0, 1'b1, 2'b01); tick();
    cmd_write(5'd9, 18'h00000, 1'b1, 1'b0, 2'b00); tick();
    cmd_write(5'd9, 18'h2AA55, 1'b0, 1'b1, 2'b10); tick();
    cmd_write(5'd10, 18'h15A5A, 1'b1, 1'b1, 2'b01); tick();
    cmd_write(5'd11, 18'h0C3C3, 1'b1, 1'b0, 2'b00); tick();
    cmd_read(5'd8); tick();
    chk_word("R4 lane0 cleared", 18'h3FE00);
    cmd_read(5'd9); tick();
    chk_word("R4 lane1 written", 18'h2AA00);
    cmd_read(5'd10); tick();
    chk_word("R5 global over byte controls", 18'h15A5A);
    cmd_read(5'd11); tick();
    chk_word("R5 global with no byte enable", 18'h0C3C3);
    cmd_write(5'd10, 18'h00000, 1'b0, 1'b1, 2'b00); tick();
    chk_word("R6 empty byte write acts as read", 18'h15A5A);
    cmd_read(5'd10); tick();
    chk_word("R6 array unchanged", 18'h15A5A);
    cmd_idle(); tick(); tick();
  endtask

  task automatic t_oe();
    cmd_read(5'd11); tick();
    chk_word("R10 oe high", 18'h0C3C3);
    oe = 1'b0; #1;
    chk_on("R10 oe low async", 1'b0);
    oe = 1'b1; #1;
    chk_word("R10 oe restored", 18'h0C3C3);
    cmd_idle(); tick(); tick();
  endtask

  task automatic t_pipe();
    pipe_mode = 1'b1;
    tick(); tick(); tick();
    cmd_read(5'd8); tick();
    chk_on("R3 not yet after first edge", 1'b0);
    cmd_read(5'd9); tick();
    chk_word("R3 pipelined first word", 18'h3FE00);
    cmd_idle(); tick();
    chk_word("R3 pipelined second word", 18'h2AA00);
    tick();
    chk_word("R7 pipelined hold cycle", 18'h2AA00);
    tick();
    chk_on("R7 pipelined release", 1'b0);
    cmd_write(5'd12, 18'h1B2B3, 1'b1, 1'b0, 2'b00); tick();
    cmd_read(5'd12); tick();
    cmd_idle(); tick();
    chk_word("R9 pipelined read after write", 18'h1B2B3);
    tick(); tick(); tick();
    pipe_mode = 1'b0;
    tick(); tick();
  endtask

  task automatic t_sleep();
    cmd_write(5'd13, 18'h2468A, 1'b1, 1'b0, 2'b00); tick();
    cmd_idle(); tick();
    cmd_read(5'd13); tick();
    chk_word("R11 before sleep", 18'h2468A);
    sleep = 1'b1; #1;
    chk_on("R11 sleep async off", 1'b0);
    cmd_write(5'd13, 18'h13579, 1'b1, 1'b0, 2'b00); tick();
    cmd_read(5'd13); tick();
    chk_on("R11 read during sleep ignored", 1'b0);
    cmd_idle(); tick();
    sleep = 1'b0;
    tick();
    cmd_read(5'd13); tick();
    chk_word("R11 contents kept", 18'h2468A);
    cmd_idle(); tick();
  endtask

  initial begin
    t_reset();
    t_flow_read();
    t_flow_dcd();
    t_bytes();
    t_oe();
    t_pipe();
    t_sleep();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule